// File: doc/BRIEF.md
# Precise exception control unit

This block decides, each clock cycle, whether the pipeline must abandon its current flow and enter an exception handler. It watches two fault sources. One is an undefined-opcode flag raised by the decode stage. The other is an arithmetic-overflow flag raised by the execute stage. Each flag comes with the program counter of the instruction that raised it.

When at least one fault is present, the unit keeps exceptions precise by choosing the fault of the oldest instruction. The execute stage holds an older instruction than decode, so an overflow wins over an undefined opcode. In that same cycle the unit does four things:
- it raises squash signals for every stage from fetch up to the stage of the faulting instruction, so the chosen instruction and everything younger become bubbles;
- it blocks the register write of a faulting execute-stage instruction;
- it presents a handler address for the program counter;
- it loads the saved-PC and cause registers at the closing clock edge.

The handler address comes from one of two modes, picked by an input. In fixed mode every fault goes to one common address. In vectored mode each cause has its own entry point. The saved PC is the faulting address plus four, so software that wants to restart the instruction subtracts four.

Top module: `precise_trap_unit`

## Requirements
- R1: While `rst` is high, `saved_pc` and `trap_cause` reset to zero at each rising edge and ignore fault flags. This holds even when a fault flag is asserted.
- R2: In a cycle with neither fault flag set, the outputs `kill_fetch`, `kill_decode`, `kill_exec`, `block_wb` and `trap_taken` are all low.
- R3: In a cycle with `ex_ovf` high, `kill_fetch`, `kill_decode`, `kill_exec`, `block_wb` and `trap_taken` are all high in that same cycle.
- R4: In a cycle with `dec_undef` high and `ex_ovf` low, these signals are high in that cycle: `kill_fetch`, `kill_decode` and `trap_taken`. The older execute-stage instruction is left alone: `kill_exec` and `block_wb` stay low.
- R5: When both flags are high in one cycle, the overflow is taken. The squash signals follow R3, and the registers load the overflow cause and `ex_pc` plus four.
- R6: At the rising edge that ends a cycle in which a fault is taken, `saved_pc` loads the chosen instruction's PC plus four, modulo 2^32. For example, 32'hFFFF_FFFC saves as 32'h0000_0000.
- R7: At that same edge, `trap_cause` loads 0 for an undefined opcode and 1 for an overflow.
- R8: With `vec_mode` low, a taken fault drives `handler_pc` to 32'h8000_0180 for either cause.
- R9: With `vec_mode` high, a taken undefined opcode drives `handler_pc` to 32'hC000_0000 and a taken overflow drives it to 32'hC000_0020.
- R10: In any cycle without a taken fault, `saved_pc` and `trap_cause` keep their values across the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| vec_mode | input | 1 | 0 selects the common handler address, 1 selects the per-cause address |
| dec_undef | input | 1 | Decode stage holds an undefined opcode |
| dec_pc | input | 32 | PC of the instruction in decode |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc | input | 32 | PC of the instruction in execute |
| kill_fetch | output | 1 | Turn the fetch-stage slot into a bubble |
| kill_decode | output | 1 | Turn the decode-stage slot into a bubble |
| kill_exec | output | 1 | Turn the execute-stage slot into a bubble |
| block_wb | output | 1 | Suppress the register write of the faulting execute-stage instruction |
| trap_taken | output | 1 | Load `handler_pc` into the program counter this cycle |
| handler_pc | output | 32 | Handler entry address; meaningful only while `trap_taken` is high |
| saved_pc | output | 32 | Faulting PC plus four, captured when a fault is taken |
| trap_cause | output | 1 | 0 for an undefined opcode, 1 for an overflow |

## Verification
The squash, write-block and redirect outputs respond to the fault flags within the same cycle. The bench drives the flags just after a falling edge and samples these outputs 1 ns later, still in the low phase of the clock. The saved-PC and cause registers only reflect that stimulus after the following rising edge, so they are compared 1 ns after that edge. For R10 the same sampling point shows that an idle cycle left them unchanged. Each scoreboard entry carries both the same-cycle expectations and the post-edge expectations of one stimulus, and the monitor compares them at these two points in that order.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned N_STAGE = 3;
  localparam int unsigned STG_W   = $clog2(N_STAGE);

  // stage index order is behavioural: a fault squashes every stage whose index is not above its own
  localparam int unsigned IDX_FETCH  = 0;
  localparam int unsigned IDX_DECODE = 1;
  localparam int unsigned IDX_EXEC   = 2;

  typedef logic [XLEN-1:0] addr_t;

  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  typedef struct packed {
    logic             take;
    cause_e           cause;
    logic [STG_W-1:0] stage;
    addr_t            pc;
  } trap_sel_t;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic                ex_ovf,
  input  addr_t               ex_pc,
  input  logic                dec_undef,
  input  addr_t               dec_pc,
  output trap_sel_t           sel,
  output logic [N_STAGE-1:0]  squash
);
  // oldest instruction first: execute outranks decode
  always_comb begin
    sel       = '0;
    sel.cause = CAUSE_UNDEF;
    if (ex_ovf) begin
      sel.take  = 1'b1;
      sel.cause = CAUSE_OVF;
      sel.stage = STG_W'(IDX_EXEC);
      sel.pc    = ex_pc;
    end else if (dec_undef) begin
      sel.take  = 1'b1;
      sel.cause = CAUSE_UNDEF;
      sel.stage = STG_W'(IDX_DECODE);
      sel.pc    = dec_pc;
    end
  end

  // every stage from fetch up to the faulting one becomes a bubble
  for (genvar s = 0; s < int'(N_STAGE); s++) begin : g_squash
    assign squash[s] = sel.take && (sel.stage >= STG_W'(s));
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_pkg::*;
#(
  parameter addr_t FIXED_HANDLER = 32'h8000_0180,
  parameter addr_t VEC_BASE      = 32'hC000_0000,
  parameter addr_t VEC_STRIDE    = 32'h0000_0020,
  parameter bit    VECTOR_EN     = 1'b1
) (
  input  logic   vec_mode,
  input  cause_e cause,
  output addr_t  target
);
  if (VECTOR_EN) begin : g_vectored
    addr_t per_cause;
    assign per_cause = VEC_BASE + (VEC_STRIDE * addr_t'(cause));
    assign target    = vec_mode ? per_cause : FIXED_HANDLER;
  end else begin : g_fixed_only
    logic unused_sel;
    assign unused_sel = vec_mode ^ cause;
    assign target     = FIXED_HANDLER;
  end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter addr_t PC_STEP = 32'd4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   take,
  input  cause_e take_cause,
  input  addr_t  take_pc,
  output addr_t  epc_q,
  output cause_e cause_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= CAUSE_UNDEF;
    end else if (take) begin
      epc_q   <= take_pc + PC_STEP;
      cause_q <= take_cause;
    end
  end
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
  import trap_pkg::*;
#(
  parameter addr_t FIXED_HANDLER = 32'h8000_0180,
  parameter addr_t VEC_BASE      = 32'hC000_0000,
  parameter addr_t VEC_STRIDE    = 32'h0000_0020,
  parameter addr_t PC_STEP       = 32'd4,
  parameter bit    VECTOR_EN     = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vec_mode,
  input  logic            dec_undef,
  input  logic [XLEN-1:0] dec_pc,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc,
  output logic            kill_fetch,
  output logic            kill_decode,
  output logic            kill_exec,
  output logic            block_wb,
  output logic            trap_taken,
  output logic [XLEN-1:0] handler_pc,
  output logic [XLEN-1:0] saved_pc,
  output logic            trap_cause
);
  trap_sel_t          sel;
  logic [N_STAGE-1:0] squash;
  addr_t              target;
  addr_t              epc_q;
  cause_e             cause_q;

  trap_arbiter u_arb (
    .ex_ovf    (ex_ovf),
    .ex_pc     (ex_pc),
    .dec_undef (dec_undef),
    .dec_pc    (dec_pc),
    .sel       (sel),
    .squash    (squash)
  );

  trap_vector_gen #(
    .FIXED_HANDLER (FIXED_HANDLER),
    .VEC_BASE      (VEC_BASE),
    .VEC_STRIDE    (VEC_STRIDE),
    .VECTOR_EN     (VECTOR_EN)
  ) u_vec (
    .vec_mode (vec_mode),
    .cause    (sel.cause),
    .target   (target)
  );

  trap_state_regs #(
    .PC_STEP (PC_STEP)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .take       (sel.take),
    .take_cause (sel.cause),
    .take_pc    (sel.pc),
    .epc_q      (epc_q),
    .cause_q    (cause_q)
  );

  assign kill_fetch  = squash[IDX_FETCH];
  assign kill_decode = squash[IDX_DECODE];
  assign kill_exec   = squash[IDX_EXEC];
  // only an instruction caught in execute still owns a pending register write
  assign block_wb    = squash[IDX_EXEC];
  assign trap_taken  = sel.take;
  assign handler_pc  = target;
  assign saved_pc    = epc_q;
  assign trap_cause  = cause_q;
endmodule

// File: rtl/precise_trap_unit_chk.sv
module precise_trap_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        vec_mode,
  input logic        dec_undef,
  input logic [31:0] dec_pc,
  input logic        ex_ovf,
  input logic [31:0] ex_pc,
  input logic        kill_fetch,
  input logic        kill_decode,
  input logic        kill_exec,
  input logic        block_wb,
  input logic        trap_taken,
  input logic [31:0] handler_pc,
  input logic [31:0] saved_pc,
  input logic        trap_cause
);
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !(ex_ovf || dec_undef) |-> !(kill_fetch || kill_decode || kill_exec || block_wb || trap_taken));

  p_ovf_squash_r3: assert property (@(posedge clk) disable iff (rst)
    ex_ovf |-> (kill_fetch && kill_decode && kill_exec && block_wb && trap_taken));

  p_undef_spares_exec_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_undef && !ex_ovf) |-> (kill_fetch && kill_decode && trap_taken && !kill_exec && !block_wb));

  p_oldest_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_undef && ex_ovf) |=> (trap_cause && saved_pc == $past(ex_pc) + 32'd4));

  p_epc_undef_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_undef && !ex_ovf) |=> (saved_pc == $past(dec_pc) + 32'd4));

  p_cause_undef_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_undef && !ex_ovf) |=> !trap_cause);

  p_fixed_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (trap_taken && !vec_mode) |-> (handler_pc == 32'h8000_0180));

  p_vec_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    (ex_ovf && vec_mode) |-> (handler_pc == 32'hC000_0020));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(ex_ovf || dec_undef) |=> ($stable(saved_pc) && $stable(trap_cause)));
endmodule

bind precise_trap_unit precise_trap_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .vec_mode    (vec_mode),
  .dec_undef   (dec_undef),
  .dec_pc      (dec_pc),
  .ex_ovf      (ex_ovf),
  .ex_pc       (ex_pc),
  .kill_fetch  (kill_fetch),
  .kill_decode (kill_decode),
  .kill_exec   (kill_exec),
  .block_wb    (block_wb),
  .trap_taken  (trap_taken),
  .handler_pc  (handler_pc),
  .saved_pc    (saved_pc),
  .trap_cause  (trap_cause)
);

// File: tb/precise_trap_unit_tb.sv
`timescale 1ns/1ps
module precise_trap_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vec_mode = 1'b0;
  logic        dec_undef = 1'b0;
  logic [31:0] dec_pc = '0;
  logic        ex_ovf = 1'b0;
  logic [31:0] ex_pc = '0;
  logic        kill_fetch, kill_decode, kill_exec, block_wb, trap_taken;
  logic [31:0] handler_pc, saved_pc;
  logic        trap_cause;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  precise_trap_unit u_dut (
    .clk(clk), .rst(rst), .vec_mode(vec_mode),
    .dec_undef(dec_undef), .dec_pc(dec_pc),
    .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .kill_fetch(kill_fetch), .kill_decode(kill_decode), .kill_exec(kill_exec),
    .block_wb(block_wb), .trap_taken(trap_taken), .handler_pc(handler_pc),
    .saved_pc(saved_pc), .trap_cause(trap_cause)
  );

  typedef struct {
    string       tag;
    logic        kf, kd, ke, wb, tk, vm;
    logic [31:0] hpc;
    logic [31:0] epc;
    logic        cause;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_epc   = '0;
  logic        m_cause = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what it must produce
  task automatic apply(input logic ovf, input logic undef, input logic vm,
                       input logic [31:0] xpc, input logic [31:0] dpc, input string tag);
    exp_t e;
    logic take;
    @(negedge clk);
    ex_ovf = ovf; dec_undef = undef; vec_mode = vm; ex_pc = xpc; dec_pc = dpc;
    take  = ovf | undef;
    e.tag = tag;
    e.kf  = take; e.kd = take; e.ke = ovf; e.wb = ovf; e.tk = take; e.vm = vm;
    e.hpc = !vm ? 32'h8000_0180 : (ovf ? 32'hC000_0020 : 32'hC000_0000);
    if (take) begin
      m_epc   = (ovf ? xpc : dpc) + 32'd4;
      m_cause = ovf;
    end
    e.epc   = m_epc;
    e.cause = m_cause;
    sb.push_back(e);
  endtask

  // monitor: same-cycle outputs in the low phase, registers just after the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        string rq;
        e = sb.pop_front();
        chk(e.tag, "kill_fetch",  {31'd0, kill_fetch},  {31'd0, e.kf});
        chk(e.tag, "kill_decode", {31'd0, kill_decode}, {31'd0, e.kd});
        chk(e.tag, "kill_exec",   {31'd0, kill_exec},   {31'd0, e.ke});
        chk(e.tag, "block_wb",    {31'd0, block_wb},    {31'd0, e.wb});
        chk(e.tag, "trap_taken",  {31'd0, trap_taken},  {31'd0, e.tk});
        if (e.tk) begin
          rq = e.vm ? "R9" : "R8";
          chk(rq, "handler_pc", handler_pc, e.hpc);
        end
        @(posedge clk);
        #1;
        rq = e.tk ? "R6" : "R10";
        chk(rq, "saved_pc", saved_pc, e.epc);
        rq = e.tk ? "R7" : "R10";
        chk(rq, "trap_cause", {31'd0, trap_cause}, {31'd0, e.cause});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates even with a fault flag raised
    @(negedge clk);
    ex_ovf = 1'b1; ex_pc = 32'h0000_1000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "saved_pc",   saved_pc, 32'h0);
    chk("R1", "trap_cause", {31'd0, trap_cause}, 32'h0);
    @(negedge clk);
    ex_ovf = 1'b0;
    rst = 1'b0;

    apply(0, 0, 0, 32'h0, 32'h0, "R2");
    apply(0, 0, 1, 32'h0, 32'h0, "R2");
    apply(0, 1, 0, 32'h0000_0048, 32'h0000_0040, "R4");
    apply(0, 0, 0, 32'h0000_0010, 32'h0000_0020, "R10");
    apply(1, 0, 0, 32'h0000_004C, 32'h0000_0050, "R3");
    apply(0, 0, 0, 32'h0, 32'h0, "R10");
    apply(1, 1, 0, 32'h0000_0200, 32'h0000_0100, "R5");
    apply(0, 1, 1, 32'h0000_0300, 32'h0000_0304, "R4");
    apply(1, 0, 1, 32'h0000_0400, 32'h0000_0404, "R3");
    apply(1, 1, 1, 32'h0000_0500, 32'h0000_0504, "R5");
    apply(0, 1, 0, 32'h0, 32'hFFFF_FFFC, "R6");
    apply(1, 0, 1, 32'hFFFF_FFFC, 32'h0, "R6");
    apply(0, 0, 1, 32'h1234_5678, 32'h9ABC_DEF0, "R10");
    for (int i = 0; i < 8; i++) begin
      apply(i[0], i[1], i[2], 32'h0010_0000 + 32'(i) * 32'h44,
            32'h0020_0000 + 32'(i) * 32'h3C, (i[0] | i[1]) ? "R7" : "R2");
    end
    apply(0, 0, 0, 32'h0, 32'h0, "R10");

    wait (sb.size() == 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule